// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a synchronous word-wide memory with registered inputs and a registered read path. Its word address is 16 bits wide, its data path is 32 bits wide and split into four byte lanes, and it uses one shared data bus in each direction. A processor-side strobe or a controller-side strobe starts an access, and three chip selects qualify it. Once an access is open, an advance input walks the two low address bits through a four-beat wraparound sequence. A static order input chooses a linear or an interleaved sequence. Each continued beat keeps the direction, read or write, of the access in progress.

The two strobes follow different write rules. A write opened by the processor strobe takes two clocks: the write inputs are ignored in the strobe cycle, and the data and byte enables are taken at the following edge. A write opened by the controller strobe completes on its own edge. Read data goes through one output register, so it appears one clock after the address is captured. The drive enable for the data bus is gated by an asynchronous output enable. It is also forced off in the first cycle after selection, after a deselect and whenever a write is signalled. The storage is a behavioural array of DEPTH words (a power of two), indexed by the low address bits.

Top module: `bsram_ctrl`

## Requirements
- R1: A read captured at clock edge k (controller strobe with no write inputs active, or processor strobe) puts the addressed word on dq_out with dq_drive high after edge k+1, provided oe_n is low and no write input is active.
- R2: In the cycle between the strobe edge and the next edge of an access started from the deselected state, dq_drive stays low.
- R3: While sel1_n is high, the processor strobe is ignored. No access starts, and write inputs in the following cycle change no stored word.
- R4: For a processor-strobe write, write inputs in the strobe cycle have no effect. The data and byte enables sampled at the next edge are written to the captured address.
- R5: A controller-strobe write (cstb_n low, pstb_n high, all selects active, write inputs active) stores dq_in at that same edge.
- R6: Byte lane i is bits 8i+7..8i. gw_n low writes all four lanes and overrides bwe_n and bsel_n. Otherwise lane i is written only when bwe_n is low and bsel_n[i] is low, and the other lanes keep their values.
- R7: A strobe sampled with any chip select inactive (sel1_n high, sel2 low or sel3_n high) closes the access, and dq_drive is low from that edge on.
- R8: dq_drive is low in any cycle where gw_n is low, or bwe_n is low together with some bsel_n bit low, and in any cycle where oe_n is high, whatever the pipeline holds.
- R9: Beat n of a burst from start address s keeps the upper address bits. Its low two bits are (s+n) mod 4 when lin_order is 1 and s XOR n when lin_order is 0.
- R10: adv_n low with no strobe moves the open access to its next burst address in the same direction. adv_n high with no strobe holds the address: a read repeats the same word and a write stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Word address captured on a strobe |
| pstb_n | input | 1 | Processor-side address strobe, active low |
| cstb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select 1, active low; also gates pstb_n |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 4 | Per-lane byte select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| lin_order | input | 1 | 1 selects linear burst order, 0 interleaved |
| dq_in | input | 32 | Write data from the shared bus |
| dq_out | output | 32 | Read data from the output register |
| dq_drive | output | 1 | Bus driver enable; low means high impedance |

## Verification
A read whose word sits in the output register and a write signalled on the write inputs can land in the same cycle. In that cycle the bus must be released, and the read must return once the write inputs fall. The bench holds a burst read with adv_n high so the word stays on dq_out. It then pulls gw_n low and later bwe_n with a lane select low, without clocking, and checks that dq_drive falls and recovers while the held word is unchanged. A related collision is a processor-strobe start with write inputs already active. The bench judges it by reading back the address and comparing it with a scoreboard that applied only the second-cycle data.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {ORD_XOR = 1'b0, ORD_ADD = 1'b1} burst_ord_e;

  // low two address bits of burst beat 'step' from start offset 'first'
  function automatic logic [1:0] beat_lo(input logic lin, input logic [1:0] first,
                                         input logic [1:0] step);
    return (burst_ord_e'(lin) == ORD_ADD) ? (first + step) : (first ^ step);
  endfunction
endpackage

// File: rtl/bsram_burst_seq.sv
`timescale 1ns/1ps
module bsram_burst_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          lin,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  import bsram_pkg::*;

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nxt;

  assign cnt_nxt  = cnt_q + 2'd1;
  assign cur_addr = {base_q[AW-1:2], beat_lo(lin, base_q[1:0], cnt_q)};
  assign nxt_addr = {base_q[AW-1:2], beat_lo(lin, base_q[1:0], cnt_nxt)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= start_addr;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/bsram_decode.sv
`timescale 1ns/1ps
module bsram_decode #(
  parameter int NB = 4
) (
  input  logic          pstb_n,
  input  logic          cstb_n,
  input  logic          sel1_n,
  input  logic          sel2,
  input  logic          sel3_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bsel_n,
  input  logic          active_q,
  output logic          p_go,
  output logic          c_wr,
  output logic          c_rd,
  output logic          desel,
  output logic          cont,
  output logic          wr_req,
  output logic [NB-1:0] bmask
);
  logic sel_ok, p_take, c_take, strobe;

  assign sel_ok = !sel1_n && sel2 && !sel3_n;
  assign p_take = !pstb_n && !sel1_n;
  assign c_take = !cstb_n && !p_take;
  assign strobe = p_take || c_take;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign bmask[i] = !gw_n || (!bwe_n && !bsel_n[i]);
  end
  assign wr_req = |bmask;

  assign p_go  = p_take && sel_ok;
  assign c_wr  = c_take && sel_ok && pstb_n && wr_req;
  assign c_rd  = c_take && sel_ok && !wr_req;
  assign desel = strobe && !sel_ok;
  assign cont  = !strobe && active_q;
endmodule

// File: rtl/bsram_core.sv
`timescale 1ns/1ps
module bsram_core #(
  parameter int AW    = 16,
  parameter int DEPTH = 1024,
  parameter int NB    = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [NB-1:0]      wmask,
  input  logic [NB*8-1:0]    wdata,
  input  logic               re,
  input  logic [AW-1:0]      raddr,
  output logic [NB*8-1:0]    rdata
);
  import bsram_pkg::*;
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0] widx, ridx;
  assign widx = waddr[IW-1:0];
  assign ridx = raddr[IW-1:0];

  if (IW < AW) begin : g_fold
    logic unused_hi;
    assign unused_hi = ^{waddr[AW-1:IW], raddr[AW-1:IW]};
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BYTE_W-1:0] lane [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wmask[b]) lane[widx] <= wdata[b*BYTE_W +: BYTE_W];
      if (re)             rdata[b*BYTE_W +: BYTE_W] <= lane[ridx];
    end
  end
endmodule

// File: rtl/bsram_ctrl.sv
`timescale 1ns/1ps
module bsram_ctrl #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          pstb_n,
  input  logic          cstb_n,
  input  logic          adv_n,
  input  logic          sel1_n,
  input  logic          sel2,
  input  logic          sel3_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [DW/8-1:0] bsel_n,
  input  logic          oe_n,
  input  logic          lin_order,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_drive
);
  localparam int NB = DW / 8;

  // access state
  logic          active_q, dir_wr_q, pfirst_q, rd_pend_q, show_q;
  logic [AW-1:0] rd_addr_q;

  // decoded events
  logic p_go, c_wr, c_rd, desel, cont, wr_req;
  logic [NB-1:0] bmask;
  logic start, ev_p2, ev_adv, ev_hold, ev_bwr, ev_brd;

  // datapath
  logic [AW-1:0] cur, nxt, waddr, rd_addr_d;
  logic          we, rd_pend_d;

  bsram_decode #(.NB(NB)) u_dec (
    .pstb_n(pstb_n), .cstb_n(cstb_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .active_q(active_q), .p_go(p_go), .c_wr(c_wr), .c_rd(c_rd),
    .desel(desel), .cont(cont), .wr_req(wr_req), .bmask(bmask)
  );

  assign start   = p_go || c_wr || c_rd;
  assign ev_p2   = cont && pfirst_q && wr_req;
  assign ev_adv  = cont && !adv_n && !ev_p2;
  assign ev_hold = cont && adv_n && !ev_p2;
  assign ev_bwr  = ev_adv && dir_wr_q;
  assign ev_brd  = ev_adv && !dir_wr_q;

  bsram_burst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(start), .step(ev_adv),
    .lin(lin_order), .start_addr(addr), .cur_addr(cur), .nxt_addr(nxt)
  );

  // write port select
  always_comb begin
    we = c_wr || ev_p2 || ev_bwr;
    if (c_wr)       waddr = addr;
    else if (ev_p2) waddr = cur;
    else            waddr = nxt;
  end

  // read pipeline stage 1
  always_comb begin
    rd_pend_d = 1'b0;
    rd_addr_d = rd_addr_q;
    if (p_go || c_rd) begin
      rd_pend_d = 1'b1;
      rd_addr_d = addr;
    end else if (ev_brd) begin
      rd_pend_d = 1'b1;
      rd_addr_d = nxt;
    end else if (ev_hold && !dir_wr_q) begin
      rd_pend_d = 1'b1;
      rd_addr_d = cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      dir_wr_q  <= 1'b0;
      pfirst_q  <= 1'b0;
      rd_pend_q <= 1'b0;
      show_q    <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      if (start)      active_q <= 1'b1;
      else if (desel) active_q <= 1'b0;
      if (c_wr || ev_p2)       dir_wr_q <= 1'b1;
      else if (p_go || c_rd)   dir_wr_q <= 1'b0;
      pfirst_q  <= p_go;
      rd_pend_q <= rd_pend_d;
      rd_addr_q <= rd_addr_d;
      show_q    <= rd_pend_q && !desel && !we;
    end
  end

  bsram_core #(.AW(AW), .DEPTH(DEPTH), .NB(NB)) u_core (
    .clk(clk), .we(we), .waddr(waddr), .wmask(bmask), .wdata(dq_in),
    .re(rd_pend_q), .raddr(rd_addr_q), .rdata(dq_out)
  );

  assign dq_drive = show_q && !oe_n && !wr_req;
endmodule

// File: rtl/bsram_chk.sv
`timescale 1ns/1ps
module bsram_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pstb_n,
  input logic          cstb_n,
  input logic          sel1_n,
  input logic          gw_n,
  input logic          oe_n,
  input logic          dq_drive,
  input logic          start,
  input logic          desel,
  input logic          we,
  input logic          c_wr,
  input logic          ev_p2,
  input logic          ev_bwr,
  input logic          ev_hold,
  input logic          active_q,
  input logic          dir_wr_q,
  input logic          rd_pend_q,
  input logic          show_q,
  input logic [AW-1:0] rd_addr_q
);
  assert_read_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend_q && !desel && !we) |=> show_q);

  assert_first_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active_q) |=> !dq_drive);

  assert_pstb_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n && sel1_n && cstb_n && !active_q) |=> !active_q);

  assert_one_wsrc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c_wr, ev_p2, ev_bwr}));

  assert_desel_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !dq_drive);

  assert_oe_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_drive);

  assert_gw_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gw_n |-> !dq_drive);

  assert_hold_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hold && !dir_wr_q) |=> (rd_pend_q && $stable(rd_addr_q)));
endmodule

bind bsram_ctrl bsram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pstb_n(pstb_n), .cstb_n(cstb_n),
  .sel1_n(sel1_n), .gw_n(gw_n), .oe_n(oe_n), .dq_drive(dq_drive),
  .start(start), .desel(desel), .we(we), .c_wr(c_wr), .ev_p2(ev_p2),
  .ev_bwr(ev_bwr), .ev_hold(ev_hold), .active_q(active_q),
  .dir_wr_q(dir_wr_q), .rd_pend_q(rd_pend_q), .show_q(show_q),
  .rd_addr_q(rd_addr_q)
);

// File: tb/sim_bsram_ctrl.sv
`timescale 1ns/1ps
module sim_bsram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
  logic        sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
  logic        gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]  bsel_n = 4'hF;
  logic        oe_n = 1'b0, lin_order = 1'b1;
  logic [31:0] dq_in = '0;
  logic [31:0] dq_out;
  logic        dq_drive;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] sb [0:63];

  always #10 clk = ~clk;

  bsram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .pstb_n(pstb_n), .cstb_n(cstb_n),
    .adv_n(adv_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
    .lin_order(lin_order), .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  task automatic chk(input bit ok, input string req, input logic [32:0] act,
                     input logic [32:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1;
    sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF; oe_n = 1'b0;
  endtask

  // lanes written according to the byte-write rule of R6
  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic g, input logic b, input logic [3:0] s);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++)
      if (!g || (!b && !s[i])) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [15:0] beat(input logic [15:0] s, input int n, input logic lin);
    logic [1:0] lo;
    lo = lin ? 2'(s[1:0] + 2'(n)) : (s[1:0] ^ 2'(n));
    return {s[15:2], lo};
  endfunction

  task automatic deselect(input string req);
    idle(); cstb_n = 1'b0; sel2 = 1'b0;
    tick(); idle();
    chk(dq_drive == 1'b0, req, {32'h0, dq_drive}, 33'h0);
  endtask

  task automatic read_check(input logic [15:0] a, input string req);
    idle(); addr = a; cstb_n = 1'b0;
    tick(); idle();
    chk(dq_drive == 1'b0, "R2 first cycle", {32'h0, dq_drive}, 33'h0);
    tick();
    chk(dq_drive && dq_out == sb[a[5:0]], req, {dq_drive, dq_out}, {1'b1, sb[a[5:0]]});
    deselect("R7 deselect");
  endtask

  task automatic c_write(input logic [15:0] a, input logic [31:0] d, input logic g,
                         input logic b, input logic [3:0] s);
    idle(); addr = a; cstb_n = 1'b0; dq_in = d; gw_n = g; bwe_n = b; bsel_n = s;
    tick(); idle();
    sb[a[5:0]] = merge(sb[a[5:0]], d, g, b, s);
    deselect("R7 after write");
  endtask

  task automatic t_init();
    for (int i = 0; i < 64; i++) begin
      sb[i] = 32'h0;
      c_write(16'(i), 32'h1000_0000 + 32'(i) * 32'h0101_0101, 1'b0, 1'b1, 4'hF);
    end
    read_check(16'd5, "R5 controller write");
  endtask

  task automatic t_byte_mask();
    c_write(16'd9, 32'hAABB_CCDD, 1'b1, 1'b0, 4'b1010);
    read_check(16'd9, "R6 lanes 0 and 2");
    c_write(16'd10, 32'h5566_7788, 1'b0, 1'b1, 4'b1110);
    read_check(16'd10, "R6 global override");
    c_write(16'd11, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'h0);
    read_check(16'd11, "R6 selects without enable");
  endtask

  task automatic t_pwrite(input logic [15:0] a, input logic [31:0] d,
                          input logic g, input logic b, input logic [3:0] s);
    idle(); addr = a; pstb_n = 1'b0; gw_n = 1'b0; dq_in = ~d;
    tick(); idle();
    gw_n = g; bwe_n = b; bsel_n = s; dq_in = d;
    tick(); idle();
    sb[a[5:0]] = merge(sb[a[5:0]], d, g, b, s);
    deselect("R7 after pwrite");
    read_check(a, "R4 processor write");
  endtask

  task automatic t_pstb_gate();
    idle(); addr = 16'd20; pstb_n = 1'b0; sel1_n = 1'b1; gw_n = 1'b0; dq_in = 32'hFFFF_0000;
    tick(); idle();
    chk(dq_drive == 1'b0, "R3 no start", {32'h0, dq_drive}, 33'h0);
    gw_n = 1'b0; dq_in = 32'h0BAD_0BAD;
    tick(); idle();
    read_check(16'd20, "R3 word unchanged");
  endtask

  task automatic t_overlap();
    idle(); addr = 16'd12; cstb_n = 1'b0;
    tick(); idle();
    tick();
    chk(dq_drive && dq_out == sb[12], "R1 held read", {dq_drive, dq_out}, {1'b1, sb[12]});
    gw_n = 1'b0; #1;
    chk(dq_drive == 1'b0, "R8 global write releases bus", {32'h0, dq_drive}, 33'h0);
    gw_n = 1'b1; bwe_n = 1'b0; bsel_n = 4'b0111; #1;
    chk(dq_drive == 1'b0, "R8 byte write releases bus", {32'h0, dq_drive}, 33'h0);
    bwe_n = 1'b1; bsel_n = 4'hF; #1;
    chk(dq_drive && dq_out == sb[12], "R8 bus restored", {dq_drive, dq_out}, {1'b1, sb[12]});
    oe_n = 1'b1; #1;
    chk(dq_drive == 1'b0, "R8 output enable", {32'h0, dq_drive}, 33'h0);
    oe_n = 1'b0;
    deselect("R7 after overlap");
  endtask

  task automatic t_burst(input logic [15:0] a, input logic lin, input string req);
    logic [31:0] d;
    logic [15:0] exp_a [5];
    logic        advs [5];
    lin_order = lin;
    idle(); addr = a; cstb_n = 1'b0; gw_n = 1'b0; d = 32'hB000_0000 ^ 32'(a);
    dq_in = d;
    tick();
    sb[a[5:0]] = d;
    for (int n = 1; n < 4; n++) begin
      idle(); adv_n = 1'b0; gw_n = 1'b0; d = d + 32'h0111_0001; dq_in = d;
      tick();
      sb[beat(a, n, lin) & 16'h3F] = d;
    end
    deselect("R7 after burst write");
    advs = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    exp_a = '{beat(a, 0, lin), beat(a, 1, lin), beat(a, 1, lin),
              beat(a, 2, lin), beat(a, 3, lin)};
    idle(); addr = a; pstb_n = 1'b0;
    tick(); idle();
    chk(dq_drive == 1'b0, "R2 burst first cycle", {32'h0, dq_drive}, 33'h0);
    for (int n = 0; n < 5; n++) begin
      idle(); adv_n = advs[n];
      tick(); idle();
      chk(dq_drive && dq_out == sb[exp_a[n][5:0]], n == 2 ? "R10 hold repeats" : req,
          {dq_drive, dq_out}, {1'b1, sb[exp_a[n][5:0]]});
    end
    deselect("R7 after burst read");
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk(dq_drive == 1'b0, "reset state", {32'h0, dq_drive}, 33'h0);
    rst_n = 1'b1;
    @(negedge clk);
    t_init();
    t_byte_mask();
    t_pwrite(16'd14, 32'h1234_5678, 1'b0, 1'b1, 4'hF);
    t_pwrite(16'd15, 32'hCAFE_F00D, 1'b1, 1'b0, 4'b0101);
    t_pstb_gate();
    t_overlap();
    t_burst(16'd33, 1'b1, "R9 linear order");
    t_burst(16'd46, 1'b0, "R9 interleaved order");
    t_burst(16'd50, 1'b1, "R10 advance read");
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule